// File: doc/BRIEF.md
# Receive Frame and Multiframe Sync Pulse Generator

This block sits beside a T1 or E1 receive framer and owns one bidirectional boundary-sync signal. It runs from the receive bit clock, with one clock per bit, and counts bit positions inside a frame. It also counts frames inside a T1 superframe or extended superframe and inside the two E1 multiframes, CAS and CRC-4. In drive mode it marks the first bit of each frame or of each multiframe with a pulse. In T1 it can stretch the pulse to two bits on signaling frames. In E1 it marks either the CAS or the CRC-4 multiframe start.

After reset the block listens. A rising edge on the sync input then moves the bit counter to the frame boundary. When multiframe alignment is selected, the edge also moves the frame counters to the multiframe boundary. Each E1 frame counter has its own offset, so the two E1 multiframes need not start on the same frame. A control input turns the pin into an output.

The control FSM has five states. LISTEN drives nothing. QUIET drives low. MARK is a one-bit pulse. WIDE_HEAD and WIDE_TAIL are the two bits of a double-width pulse. The transitions are:
- Any state goes to LISTEN when the direction input is low.
- WIDE_HEAD goes to WIDE_TAIL.
- Any other driving state, or LISTEN with direction high, goes to WIDE_HEAD when the next position is bit 0 of a signaling frame with double width enabled.
- The same states go to MARK when the next position is any other qualifying bit 0.
- In all remaining cases they go to QUIET.

Top module: `rsp_sync_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sync_oe and sync_out are 0; the counters restart at bit 0, frame 0.
- R2: sync_oe equals the value of dir_out sampled at the previous clock edge (1 = drive, 0 = listen).
- R3: With mf_sel=0 and double width not applicable, sync_out is high for exactly one cycle at bit 0 of every frame; the frame length is T1_BITS bits when e1_mode=0 and E1_BITS bits when e1_mode=1.
- R4: With e1_mode=0, mf_sel=0 and dbl_sig=1, frames with index 5, 11, 17 and 23 (counted from 0) get a pulse two cycles wide, covering bits 0 and 1. All other frames get a one-cycle pulse.
- R5: With e1_mode=0 and mf_sel=1, sync_out pulses once per T1 multiframe at bit 0 of frame 0. The multiframe is 12 frames when esf_mode=0 and 24 frames when esf_mode=1.
- R6: With e1_mode=1, mf_sel=1 and crc_sel=0, sync_out pulses at bit 0 of each frame whose CAS frame count (modulo 16) is 0.
- R7: With e1_mode=1, mf_sel=1 and crc_sel=1, sync_out pulses at bit 0 of each frame whose CRC-4 frame count (modulo 16) is 0.
- R8: With dir_out=0, a clock where sync_in is 1 after being 0 in the previous clock is taken as bit 0 of a frame. If mf_sel=1, it is also frame 0 of the T1 multiframe, CAS frame cas_ofs and CRC-4 frame crc_ofs. If mf_sel=0, the frame counts keep their values.
- R9: With dir_out=1, sync_in has no effect on the pulse timing.
- R10: sync_out is 0 whenever sync_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one cycle per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1 = drive boundary pulses, 0 = accept them |
| e1_mode | input | 1 | 0 = T1 frame format, 1 = E1 |
| esf_mode | input | 1 | T1 multiframe length: 0 = 12 frames, 1 = 24 frames |
| mf_sel | input | 1 | 0 = frame boundary, 1 = multiframe boundary |
| dbl_sig | input | 1 | T1 double-width pulse on signaling frames |
| crc_sel | input | 1 | E1 multiframe marked: 0 = CAS, 1 = CRC-4 |
| cas_ofs | input | CW | CAS frame count loaded on multiframe realignment |
| crc_ofs | input | CW | CRC-4 frame count loaded on multiframe realignment |
| sync_in | input | 1 | Boundary pulse from the pin in listen mode |
| sync_oe | output | 1 | Pin output enable |
| sync_out | output | 1 | Boundary pulse driven to the pin |

## Verification
The bench realigns the counters with edges that fall in the middle of a frame and then switches to drive mode. A design that reloads the bit counter to 0 instead of 1 on the edge would put every later pulse one bit late. It also holds sync_in high across many clocks, where a level-sensitive design would realign again and again. It toggles sync_in in drive mode, which must not move the pulses. Random segments change the E1 offsets, the multiframe length and the CAS/CRC-4 choice. These catch a shared E1 frame counter, a wrong signaling-frame index, and a tail bit that leaks into multiframe mode.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    typedef enum logic [2:0] {
        S_LISTEN    = 3'd0,
        S_QUIET     = 3'd1,
        S_MARK      = 3'd2,
        S_WIDE_HEAD = 3'd3,
        S_WIDE_TAIL = 3'd4
    } rsp_state_e;
endpackage

// File: rtl/rsp_counters.sv
module rsp_counters #(
    parameter int T1_BITS = 193,
    parameter int E1_BITS = 256,
    parameter int T1_SF   = 12,
    parameter int T1_ESF  = 24,
    parameter int E1_MF   = 16,
    parameter int BW      = 8,
    parameter int FW      = 5,
    parameter int CW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          e1_mode,
    input  logic          esf_mode,
    input  logic          realign,
    input  logic          load_mf,
    input  logic [CW-1:0] cas_ofs,
    input  logic [CW-1:0] crc_ofs,
    output logic [BW-1:0] bit_q,
    output logic [BW-1:0] bit_n,
    output logic [FW-1:0] t1_n,
    output logic [CW-1:0] cas_n,
    output logic [CW-1:0] crc_n
);
    logic [FW-1:0] t1_q;
    logic [CW-1:0] cas_q, crc_q;
    logic [BW-1:0] last_bit;
    logic [FW-1:0] t1_last;
    logic          wrap;

    always_comb begin
        last_bit = e1_mode ? BW'(E1_BITS - 1) : BW'(T1_BITS - 1);
        t1_last  = esf_mode ? FW'(T1_ESF - 1) : FW'(T1_SF - 1);
        wrap     = (bit_q >= last_bit);
        bit_n    = wrap ? '0 : bit_q + BW'(1);
        t1_n     = t1_q;
        cas_n    = cas_q;
        crc_n    = crc_q;
        if (realign) begin
            // the edge cycle is bit 0, so the next cycle is bit 1
            bit_n = BW'(1);
            if (load_mf) begin
                t1_n  = '0;
                cas_n = cas_ofs;
                crc_n = crc_ofs;
            end
        end else if (wrap) begin
            t1_n  = (t1_q >= t1_last) ? '0 : t1_q + FW'(1);
            cas_n = (cas_q == CW'(E1_MF - 1)) ? '0 : cas_q + CW'(1);
            crc_n = (crc_q == CW'(E1_MF - 1)) ? '0 : crc_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            t1_q  <= '0;
            cas_q <= '0;
            crc_q <= '0;
        end else begin
            bit_q <= bit_n;
            t1_q  <= t1_n;
            cas_q <= cas_n;
            crc_q <= crc_n;
        end
    end
endmodule

// File: rtl/rsp_qualify.sv
module rsp_qualify #(
    parameter int SIG_GAP = 6,
    parameter int BW      = 8,
    parameter int FW      = 5,
    parameter int CW      = 4
) (
    input  logic          e1_mode,
    input  logic          mf_sel,
    input  logic          dbl_sig,
    input  logic          crc_sel,
    input  logic [BW-1:0] bit_n,
    input  logic [FW-1:0] t1_n,
    input  logic [CW-1:0] cas_n,
    input  logic [CW-1:0] crc_n,
    output logic          hit,
    output logic          wide
);
    logic sig_frame;

    always_comb begin
        sig_frame = ((int'(t1_n) % SIG_GAP) == SIG_GAP - 1);
        hit  = 1'b0;
        wide = 1'b0;
        if (bit_n == '0) begin
            if (!mf_sel) begin
                hit  = 1'b1;
                wide = !e1_mode && dbl_sig && sig_frame;
            end else if (e1_mode) begin
                hit = crc_sel ? (crc_n == '0) : (cas_n == '0);
            end else begin
                hit = (t1_n == '0);
            end
        end
    end
endmodule

// File: rtl/rsp_sync_gen.sv
module rsp_sync_gen
    import rsp_pkg::*;
#(
    parameter int T1_BITS = 193,
    parameter int E1_BITS = 256,
    parameter int T1_SF   = 12,
    parameter int T1_ESF  = 24,
    parameter int E1_MF   = 16,
    parameter int SIG_GAP = 6,
    localparam int BW     = $clog2((T1_BITS > E1_BITS) ? T1_BITS : E1_BITS),
    localparam int FW     = $clog2(T1_ESF),
    localparam int CW     = $clog2(E1_MF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_out,
    input  logic          e1_mode,
    input  logic          esf_mode,
    input  logic          mf_sel,
    input  logic          dbl_sig,
    input  logic          crc_sel,
    input  logic [CW-1:0] cas_ofs,
    input  logic [CW-1:0] crc_ofs,
    input  logic          sync_in,
    output logic          sync_oe,
    output logic          sync_out
);
    rsp_state_e    state_q, state_n;
    logic          sync_d;
    logic          realign;
    logic [BW-1:0] bit_q, bit_n;
    logic [FW-1:0] t1_n;
    logic [CW-1:0] cas_n, crc_n;
    logic          hit, wide;

    assign realign = !dir_out && sync_in && !sync_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_d <= 1'b0;
        else        sync_d <= sync_in;
    end

    rsp_counters #(
        .T1_BITS(T1_BITS), .E1_BITS(E1_BITS), .T1_SF(T1_SF), .T1_ESF(T1_ESF),
        .E1_MF(E1_MF), .BW(BW), .FW(FW), .CW(CW)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .esf_mode(esf_mode),
        .realign(realign), .load_mf(mf_sel), .cas_ofs(cas_ofs), .crc_ofs(crc_ofs),
        .bit_q(bit_q), .bit_n(bit_n), .t1_n(t1_n), .cas_n(cas_n), .crc_n(crc_n)
    );

    rsp_qualify #(.SIG_GAP(SIG_GAP), .BW(BW), .FW(FW), .CW(CW)) u_qual (
        .e1_mode(e1_mode), .mf_sel(mf_sel), .dbl_sig(dbl_sig), .crc_sel(crc_sel),
        .bit_n(bit_n), .t1_n(t1_n), .cas_n(cas_n), .crc_n(crc_n),
        .hit(hit), .wide(wide)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_LISTEN;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = S_QUIET;
        if (!dir_out) begin
            state_n = S_LISTEN;
        end else begin
            unique case (state_q)
                S_WIDE_HEAD: state_n = S_WIDE_TAIL;
                S_LISTEN, S_QUIET, S_MARK, S_WIDE_TAIL:
                    state_n = hit ? (wide ? S_WIDE_HEAD : S_MARK) : S_QUIET;
                default: state_n = S_QUIET;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            S_LISTEN:                       begin sync_oe = 1'b0; sync_out = 1'b0; end
            S_QUIET:                        begin sync_oe = 1'b1; sync_out = 1'b0; end
            S_MARK, S_WIDE_HEAD, S_WIDE_TAIL: begin sync_oe = 1'b1; sync_out = 1'b1; end
            default:                        begin sync_oe = 1'b0; sync_out = 1'b0; end
        endcase
    end
endmodule

// File: rtl/rsp_sync_gen_chk.sv
module rsp_sync_gen_chk
    import rsp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       dir_out,
    input logic       sync_in,
    input logic       sync_oe,
    input logic       sync_out,
    input logic       at_bit0,
    input logic       at_bit1,
    input rsp_state_e state
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (sync_oe == $past(dir_out)));

    assert_quiet_when_listening_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_oe |-> !sync_out);

    assert_pulse_starts_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(sync_out)) |-> at_bit0);

    assert_pulse_max_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sync_out && $past(sync_out)) |=> !sync_out);

    assert_wide_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WIDE_HEAD && dir_out) |=> (sync_out && at_bit1));

    assert_realign_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !dir_out && sync_in && !$past(sync_in)) |=> at_bit1);
endmodule

bind rsp_sync_gen rsp_sync_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .sync_in(sync_in),
    .sync_oe(sync_oe), .sync_out(sync_out),
    .at_bit0(bit_q == '0), .at_bit1(bit_q == 1), .state(state_q)
);

// File: tb/rsp_sync_gen_tb.sv
module rsp_sync_gen_tb;
    localparam int T1B = 13;
    localparam int E1B = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_out = 0, e1_mode = 0, esf_mode = 0, mf_sel = 0, dbl_sig = 0, crc_sel = 0;
    logic [3:0] cas_ofs = 0, crc_ofs = 0;
    logic sync_in = 0;
    logic sync_oe, sync_out;

    always #4 clk = ~clk;

    rsp_sync_gen #(.T1_BITS(T1B), .E1_BITS(E1B)) u_dut (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .e1_mode(e1_mode),
        .esf_mode(esf_mode), .mf_sel(mf_sel), .dbl_sig(dbl_sig), .crc_sel(crc_sel),
        .cas_ofs(cas_ofs), .crc_ofs(crc_ofs), .sync_in(sync_in),
        .sync_oe(sync_oe), .sync_out(sync_out)
    );

    // reference model built from the requirements
    int  m_bit, m_t1, m_cas, m_crc;
    bit  m_prev, m_oe, m_out, m_tail;
    int  n_checks = 0, n_fail = 0, cycles = 0;
    bit  done = 0;
    string tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_bit = 0; m_t1 = 0; m_cas = 0; m_crc = 0;
            m_prev = 0; m_oe = 0; m_out = 0; m_tail = 0;
        end else begin
            int flen, mlen;
            bit qual, dbl;
            flen = e1_mode ? E1B : T1B;
            mlen = esf_mode ? 24 : 12;
            if (!dir_out && sync_in && !m_prev) begin
                m_bit = 1;
                if (mf_sel) begin m_t1 = 0; m_cas = cas_ofs; m_crc = crc_ofs; end
            end else if (m_bit + 1 >= flen) begin
                m_bit = 0;
                m_t1  = (m_t1 + 1 >= mlen) ? 0 : m_t1 + 1;
                m_cas = (m_cas + 1) % 16;
                m_crc = (m_crc + 1) % 16;
            end else begin
                m_bit = m_bit + 1;
            end
            m_prev = sync_in;
            if (!mf_sel) begin
                qual = 1; dbl = !e1_mode && dbl_sig && ((m_t1 + 1) % 6 == 0);
            end else begin
                dbl = 0;
                qual = e1_mode ? (crc_sel ? m_crc == 0 : m_cas == 0) : m_t1 == 0;
            end
            if (!dir_out) begin
                m_oe = 0; m_out = 0; m_tail = 0;
            end else if (m_tail) begin
                m_oe = 1; m_out = 1; m_tail = 0;
            end else begin
                m_oe = 1; m_out = (m_bit == 0) && qual; m_tail = m_out && dbl;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (sync_oe !== m_oe) begin
                n_fail++;
                $display("FAIL %s sync_oe actual=%b expected=%b t=%0t",
                         (rst_n ? "R2" : "R1"), sync_oe, m_oe, $time);
            end else if (sync_out !== m_out) begin
                n_fail++;
                $display("FAIL %s sync_out actual=%b expected=%b t=%0t",
                         (!rst_n ? "R1" : (!m_oe ? "R10" : tag)), sync_out, m_out, $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic string cfg_tag();
        if (!dir_out) return "R10";
        if (mf_sel) return e1_mode ? (crc_sel ? "R7" : "R6") : "R5";
        return (!e1_mode && dbl_sig) ? "R4" : "R3";
    endfunction

    initial begin
        void'($urandom(32'h5EED_2024));
        tag = "R1";
        run(4);
        rst_n = 1'b1;
        run(3);

        // R8: mid-frame realignment on a multiframe edge, then drive
        tag = "R8";
        mf_sel = 1; esf_mode = 0;
        run(7);
        sync_in = 1; run(1);
        run(40);            // level held high must not realign again
        sync_in = 0; run(5);
        dir_out = 1;
        run(T1B * 12 * 3);
        // R8 with frame-only realignment in E1 keeps the frame counts
        dir_out = 0; e1_mode = 1; mf_sel = 0; crc_sel = 1; cas_ofs = 4'd9; crc_ofs = 4'd3;
        run(11); sync_in = 1; run(2); sync_in = 0; run(3);
        dir_out = 1; mf_sel = 1;
        run(E1B * 16 * 2);

        // R9: sync_in toggling while driving
        tag = "R9";
        e1_mode = 0; mf_sel = 1; esf_mode = 1;
        for (int i = 0; i < T1B * 24 * 2; i++) begin
            sync_in = ($urandom % 3 == 0);
            run(1);
        end
        sync_in = 0;

        // R4: extended superframe with double-wide signaling pulses
        tag = "R4";
        mf_sel = 0; dbl_sig = 1; esf_mode = 1;
        run(T1B * 24 * 2);

        // R2/R10: direction toggling
        tag = "R2";
        for (int i = 0; i < 60; i++) begin
            dir_out = $urandom % 2;
            run(1 + $urandom % 4);
        end

        // random segments
        for (int s = 0; s < 60; s++) begin
            e1_mode  = $urandom % 2;
            esf_mode = $urandom % 2;
            mf_sel   = $urandom % 2;
            dbl_sig  = $urandom % 2;
            crc_sel  = $urandom % 2;
            cas_ofs  = 4'($urandom);
            crc_ofs  = 4'($urandom);
            dir_out  = ($urandom % 4 != 0);
            tag = cfg_tag();
            if (!dir_out) tag = "R8";
            for (int i = 0; i < 600; i++) begin
                if ($urandom % 97 == 0) sync_in = ~sync_in;
                run(1);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule